// File: doc/BRIEF.md
# Foveal Row Resampler (Horizontal Stage)

This block does the horizontal half of a separable foveal mapping. The resolution varies smoothly across the mapping. It takes a row of 512 streamed pixels and reduces it to 64 output pixels. The outputs are narrow near the row centre and wide toward both ends. Each output is a running pair: a weighted pixel sum and the area that contributed to it. Both are kept in sixteenths of a pixel. When an output is complete, it is presented for one cycle with a valid token and its index. A later vertical stage combines these pairs across rows and divides sum by area.

The right-hand boundary of each output is held as a fixed-point position in input coordinates: a column number and a 4-bit fraction. The pixel whose column equals the boundary's integer part is split between the two outputs it straddles. The closing output receives `frac/16` of the pixel. The next output opens with the remaining `(16-frac)/16`. The weights come from shift-and-add, not a multiplier.

The mapping is symmetric about the row centre, so only the 32 offsets of the right half are stored. Boundaries in the left half are produced by negating the offset about the centre in fixed point. This turns a fraction `f` into `16-f`. Because the last boundary lies beyond the row, the end of the row is detected by counting columns.

Top module: `fovea_row_resampler`

## Requirements
- R1: After reset, or after a `row_start` pulse that has no pixel with it, `out_valid` is low, and the next accepted pixel is column 0 for output index 0 with an empty accumulator.
- R2: A pixel whose column differs from the integer part of the current output's boundary adds `16*pixel` to the sum and 16 to the area of the current output.
- R3: A pixel whose column equals the boundary's integer part closes the current output. The output receives an extra `f*pixel` in its sum and `f` in its area, where `f` is the 4-bit boundary fraction. The next output starts with sum `(16-f)*pixel` and area `16-f`.
- R4: A closed output appears on `out_sum`, `out_area` and `out_index` with `out_valid` high in the cycle after the clock edge that accepted the closing pixel. `out_valid` is high for one cycle per closed output.
- R5: Within a row, tokens carry indices 0, 1, 2, … 63 in order, one higher per token.
- R6: With `E(n) = 16n + floor(3584*n*n/1024)` in sixteenths, the boundary of output `32+j` (j = 0..30) is at `256*16 + E(j+1)`.
- R7: The boundary of output `i` for i = 0..30 is at `256*16 - E(31-i)`. The boundary of output 31 is exactly 256.0, which gives column 256 a zero-weight split.
- R8: Column 511 closes output 63 with its whole pixel weight. Each complete row yields exactly 64 tokens.
- R9: Pixels after column 511 and before the next `row_start` are ignored and produce no tokens.
- R10: A `row_start` given together with a valid pixel discards any partial row and treats that pixel as column 0 of a new row.
- R11: Every token has a nonzero area and `out_sum <= out_area*255`.
- R12: Cycles with `pix_valid` low in the middle of a row leave the results unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_start | input | 1 | Begins a new row; clears the column, the output index and the accumulator |
| pix_valid | input | 1 | A pixel is present on `pix_data` this cycle |
| pix_data | input | 8 | Pixel value |
| out_valid | output | 1 | A completed output is present this cycle |
| out_index | output | 6 | Index of the completed output, 0..63 |
| out_sum | output | 17 | Weighted pixel sum in sixteenths |
| out_area | output | 9 | Contributing area in sixteenths |

## Verification
The hardest conditions to reach from the ports are a `row_start` that arrives mid-row in the same cycle as a pixel, and pixels that keep arriving after the row has ended. In the first case, a token from the abandoned row can appear during the restart cycle. The stimulus creates both: it drives a partial row directly into a restart pixel, and it follows one full row with surplus pixels. Every row runs through a reference model built from the boundary formula, and some rows are fed with irregular gaps. Together these cover the zero-fraction split at the centre column and the mirrored fractions in the left half.

// File: rtl/fovea_pkg.sv
package fovea_pkg;

    // Offset of boundary n (1-based) from the row centre, in 1/2^frac_w pixel units.
    // A linear term of one pixel per output plus a quadratic growth term sized so
    // that boundary 'half' lands exactly at the end of the row.
    function automatic int unsigned edge_offset(
        input int unsigned n,
        input int unsigned half,
        input int unsigned cols,
        input int unsigned frac_w
    );
        int unsigned one;
        int unsigned total;
        int unsigned extra;
        one   = 1 << frac_w;
        total = (cols / 2) * one;
        extra = total - half * one;
        return n * one + (extra * n * n) / (half * half);
    endfunction

endpackage

// File: rtl/fovea_edge_lut.sv
module fovea_edge_lut #(
    parameter int IN_COLS  = 512,
    parameter int OUT_COLS = 64,
    parameter int FRAC_W   = 4,
    localparam int COL_W   = $clog2(IN_COLS),
    localparam int IDX_W   = $clog2(OUT_COLS)
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [COL_W:0]    edge_int,
    output logic [FRAC_W-1:0] edge_frac
);
    localparam int HALF   = OUT_COLS / 2;
    localparam int HIDX_W = $clog2(HALF);
    localparam int POS_W  = COL_W + 1 + FRAC_W;
    localparam logic [POS_W-1:0] CENTER = POS_W'(IN_COLS / 2) << FRAC_W;

    logic [POS_W-1:0] half_tab [HALF];

    // Only the right half is stored; the left half is its mirror image.
    for (genvar g = 0; g < HALF; g++) begin : g_tab
        localparam logic [POS_W-1:0] OFF =
            POS_W'(fovea_pkg::edge_offset(g + 1, HALF, IN_COLS, FRAC_W));
        assign half_tab[g] = OFF;
    end

    logic [IDX_W-1:0] right_sel;
    logic [IDX_W-1:0] left_sel;
    logic [POS_W-1:0] pos;

    always_comb begin
        right_sel = idx - IDX_W'(HALF);
        left_sel  = IDX_W'(HALF - 2) - idx;
        if (idx >= IDX_W'(HALF)) begin
            pos = CENTER + half_tab[right_sel[HIDX_W-1:0]];
        end else if (idx == IDX_W'(HALF - 1)) begin
            pos = CENTER;
        end else begin
            // Negation in fixed point turns fraction f into one minus f.
            pos = CENTER - half_tab[left_sel[HIDX_W-1:0]];
        end
        edge_int  = pos[POS_W-1:FRAC_W];
        edge_frac = pos[FRAC_W-1:0];
    end

endmodule

// File: rtl/fovea_frac_weight.sv
module fovea_frac_weight #(
    parameter int PIX_W  = 8,
    parameter int FRAC_W = 4,
    localparam int WGT_W = PIX_W + FRAC_W
) (
    input  logic [PIX_W-1:0]  pix,
    input  logic [FRAC_W-1:0] frac,
    output logic [WGT_W-1:0]  near_part,
    output logic [WGT_W-1:0]  far_part
);
    logic [WGT_W-1:0] term [FRAC_W];

    // One shifted copy of the pixel per fraction bit.
    for (genvar g = 0; g < FRAC_W; g++) begin : g_term
        assign term[g] = frac[g] ? (WGT_W'(pix) << g) : '0;
    end

    always_comb begin
        near_part = '0;
        for (int k = 0; k < FRAC_W; k++) begin
            near_part = near_part + term[k];
        end
        far_part = {pix, {FRAC_W{1'b0}}} - near_part;
    end

endmodule

// File: rtl/fovea_row_resampler.sv
module fovea_row_resampler #(
    parameter int PIX_W    = 8,
    parameter int FRAC_W   = 4,
    parameter int IN_COLS  = 512,
    parameter int OUT_COLS = 64,
    parameter int MAX_SPAN = 16,
    localparam int IDX_W   = $clog2(OUT_COLS),
    localparam int AREA_W  = FRAC_W + $clog2(MAX_SPAN) + 1,
    localparam int SUM_W   = PIX_W + AREA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_start,
    input  logic              pix_valid,
    input  logic [PIX_W-1:0]  pix_data,
    output logic              out_valid,
    output logic [IDX_W-1:0]  out_index,
    output logic [SUM_W-1:0]  out_sum,
    output logic [AREA_W-1:0] out_area
);
    localparam int COL_W = $clog2(IN_COLS);
    localparam int WGT_W = PIX_W + FRAC_W;
    localparam logic [AREA_W-1:0] ONE = AREA_W'(1 << FRAC_W);

    typedef struct packed {
        logic [COL_W-1:0]  col;
        logic [IDX_W-1:0]  idx;
        logic              done;
        logic [SUM_W-1:0]  acc_sum;
        logic [AREA_W-1:0] acc_area;
        logic              out_valid;
        logic [IDX_W-1:0]  out_idx;
        logic [SUM_W-1:0]  out_sum;
        logic [AREA_W-1:0] out_area;
    } state_t;

    state_t st_d, st_q;

    // Row-start view of the running state
    logic [COL_W-1:0]  base_col;
    logic [IDX_W-1:0]  base_idx;
    logic              base_done;
    logic [SUM_W-1:0]  base_sum;
    logic [AREA_W-1:0] base_area;

    logic [COL_W:0]    edge_int;
    logic [FRAC_W-1:0] edge_frac;
    logic [WGT_W-1:0]  near_part;
    logic [WGT_W-1:0]  far_part;
    logic [SUM_W-1:0]  whole;
    logic              at_edge;
    logic              at_end;

    always_comb begin
        if (row_start) begin
            base_col  = '0;
            base_idx  = '0;
            base_done = 1'b0;
            base_sum  = '0;
            base_area = '0;
        end else begin
            base_col  = st_q.col;
            base_idx  = st_q.idx;
            base_done = st_q.done;
            base_sum  = st_q.acc_sum;
            base_area = st_q.acc_area;
        end
    end

    fovea_edge_lut #(
        .IN_COLS (IN_COLS),
        .OUT_COLS(OUT_COLS),
        .FRAC_W  (FRAC_W)
    ) u_edge_lut (
        .idx      (base_idx),
        .edge_int (edge_int),
        .edge_frac(edge_frac)
    );

    fovea_frac_weight #(
        .PIX_W (PIX_W),
        .FRAC_W(FRAC_W)
    ) u_frac_weight (
        .pix      (pix_data),
        .frac     (edge_frac),
        .near_part(near_part),
        .far_part (far_part)
    );

    always_comb begin
        whole   = SUM_W'({pix_data, {FRAC_W{1'b0}}});
        at_edge = ({1'b0, base_col} == edge_int);
        at_end  = (base_col == COL_W'(IN_COLS - 1));

        st_d           = st_q;
        st_d.col       = base_col;
        st_d.idx       = base_idx;
        st_d.done      = base_done;
        st_d.acc_sum   = base_sum;
        st_d.acc_area  = base_area;
        st_d.out_valid = 1'b0;

        if (pix_valid && !base_done) begin
            st_d.col  = base_col + COL_W'(1);
            st_d.done = at_end;
            if (at_edge) begin
                // Split: the closing output takes the near share, the next opens with the rest.
                st_d.out_valid = 1'b1;
                st_d.out_idx   = base_idx;
                st_d.out_sum   = base_sum + SUM_W'(near_part);
                st_d.out_area  = base_area + AREA_W'(edge_frac);
                st_d.acc_sum   = SUM_W'(far_part);
                st_d.acc_area  = ONE - AREA_W'(edge_frac);
                st_d.idx       = base_idx + IDX_W'(1);
            end else if (at_end) begin
                // The final boundary lies beyond the row: close on the column count.
                st_d.out_valid = 1'b1;
                st_d.out_idx   = base_idx;
                st_d.out_sum   = base_sum + whole;
                st_d.out_area  = base_area + ONE;
                st_d.acc_sum   = '0;
                st_d.acc_area  = '0;
            end else begin
                st_d.acc_sum  = base_sum + whole;
                st_d.acc_area = base_area + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.out_valid;
    assign out_index = st_q.out_idx;
    assign out_sum   = st_q.out_sum;
    assign out_area  = st_q.out_area;

endmodule

// File: rtl/fovea_row_resampler_chk.sv
module fovea_row_resampler_chk #(
    parameter int PIX_W    = 8,
    parameter int OUT_COLS = 64,
    parameter int IDX_W    = 6,
    parameter int SUM_W    = 17,
    parameter int AREA_W   = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              row_start,
    input logic              pix_valid,
    input logic              out_valid,
    input logic [IDX_W-1:0]  out_index,
    input logic [SUM_W-1:0]  out_sum,
    input logic [AREA_W-1:0] out_area
);
    logic [IDX_W:0]   tok_cnt;
    logic [SUM_W+1:0] sum_limit;

    // Tokens seen in the current row; a token in the row_start cycle belongs to the old row.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tok_cnt <= '0;
        end else if (row_start) begin
            tok_cnt <= '0;
        end else if (out_valid) begin
            tok_cnt <= tok_cnt + (IDX_W+1)'(1);
        end
    end

    assign sum_limit = (SUM_W+2)'(out_area) * (SUM_W+2)'((1 << PIX_W) - 1);

    AST_INDEX_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_index == tok_cnt[IDX_W-1:0])); // R5

    AST_NO_EXTRA_TOKENS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (tok_cnt < (IDX_W+1)'(OUT_COLS))); // R9

    AST_TOKEN_FOLLOWS_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(pix_valid)); // R4

    AST_QUIET_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(row_start) && !$past(pix_valid)) |-> !out_valid); // R1

    AST_AREA_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_area != '0)); // R11

    AST_SUM_WITHIN_AREA: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((SUM_W+2)'(out_sum) <= sum_limit)); // R11

endmodule

bind fovea_row_resampler fovea_row_resampler_chk #(
    .PIX_W   (PIX_W),
    .OUT_COLS(OUT_COLS),
    .IDX_W   (IDX_W),
    .SUM_W   (SUM_W),
    .AREA_W  (AREA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .row_start(row_start),
    .pix_valid(pix_valid),
    .out_valid(out_valid),
    .out_index(out_index),
    .out_sum  (out_sum),
    .out_area (out_area)
);

// File: tb/tb_fovea_row_resampler.sv
module tb_fovea_row_resampler;
    localparam int CLK_PERIOD = 10;
    localparam int COLS   = 512;
    localparam int OUTS   = 64;
    localparam int HALF   = 32;
    localparam int ONE    = 16;
    localparam int IDX_W  = 6;
    localparam int SUM_W  = 17;
    localparam int AREA_W = 9;

    logic              clk;
    logic              rst_n;
    logic              row_start;
    logic              pix_valid;
    logic [7:0]        pix_data;
    logic              out_valid;
    logic [IDX_W-1:0]  out_index;
    logic [SUM_W-1:0]  out_sum;
    logic [AREA_W-1:0] out_area;

    fovea_row_resampler dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .row_start(row_start),
        .pix_valid(pix_valid),
        .pix_data (pix_data),
        .out_valid(out_valid),
        .out_index(out_index),
        .out_sum  (out_sum),
        .out_area (out_area)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        int idx;
        int sum;
        int area;
    } tok_t;

    tok_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   tok_seen = 0;
    int   pushed = 0;

    // Reference model state
    int m_col, m_idx, m_sum, m_area;
    bit m_done;

    function automatic int e_of(int n);
        return n * ONE + ((COLS / 2 * ONE - HALF * ONE) * n * n) / (HALF * HALF);
    endfunction

    // Boundary position in sixteenths (R6, R7)
    function automatic int edge_pos(int i);
        if (i < HALF - 1) return COLS / 2 * ONE - e_of(HALF - 1 - i);
        if (i == HALF - 1) return COLS / 2 * ONE;
        return COLS / 2 * ONE + e_of(i - HALF + 1);
    endfunction

    function automatic int pix_of(int pat, int c);
        case (pat)
            0: return 255;
            1: return (c * 3) & 255;
            2: return ((c * 37 + 11) ^ (c >> 2)) & 255;
            default: return (c * 13 + 200) & 255;
        endcase
    endfunction

    task automatic model_clear();
        m_col = 0; m_idx = 0; m_sum = 0; m_area = 0; m_done = 0;
    endtask

    task automatic model_pixel(int v);
        int p, f;
        tok_t t;
        if (m_done) return;
        p = edge_pos(m_idx);
        f = p % ONE;
        if (m_col == p / ONE) begin
            t.idx = m_idx; t.sum = m_sum + f * v; t.area = m_area + f;
            exp_q.push_back(t); pushed++;
            m_sum = (ONE - f) * v; m_area = ONE - f; m_idx++;
        end else begin
            m_sum += ONE * v; m_area += ONE;
            if (m_col == COLS - 1) begin
                t.idx = m_idx; t.sum = m_sum; t.area = m_area;
                exp_q.push_back(t); pushed++;
            end
        end
        if (m_col == COLS - 1) m_done = 1;
        m_col++;
    endtask

    task automatic drive_pixel(int v, bit rs);
        @(negedge clk);
        row_start = rs;
        pix_valid = 1'b1;
        pix_data  = 8'(v);
        if (rs) model_clear();
        model_pixel(v);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            row_start = 1'b0;
            pix_valid = 1'b0;
        end
    endtask

    task automatic drive_row(int pat, int first, int last, bit rs_first, int gap_mod);
        for (int c = first; c <= last; c++) begin
            drive_pixel(pix_of(pat, c), rs_first && (c == first));
            if (gap_mod > 0 && (c % gap_mod) == 2) idle(1 + (c % 3));
        end
    endtask

    task automatic check_count(string tag);
        checks++;
        if (tok_seen != pushed || exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s token count actual=%0d expected=%0d pending=%0d",
                     tag, tok_seen, pushed, exp_q.size());
        end
    endtask

    // Monitor: compare every token against the scoreboard (R2 R3 R4 R5 R6 R7)
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            tok_t t;
            tok_seen++;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R1 R9 unexpected token idx=%0d sum=%0d area=%0d expected none",
                         out_index, out_sum, out_area);
            end else begin
                t = exp_q.pop_front();
                if (int'(out_index) != t.idx || int'(out_sum) != t.sum || int'(out_area) != t.area) begin
                    errors++;
                    $display("FAIL R2 R3 R5 R6 R7 token idx=%0d sum=%0d area=%0d expected idx=%0d sum=%0d area=%0d",
                             out_index, out_sum, out_area, t.idx, t.sum, t.area);
                end
            end
        end
    end

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; row_start = 1'b0; pix_valid = 1'b0; pix_data = '0;
        model_clear();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state at the ports
        checks++;
        if (out_valid !== 1'b0 || out_index !== '0 || out_sum !== '0 || out_area !== '0) begin
            errors++;
            $display("FAIL R1 reset outputs valid=%0b idx=%0d sum=%0d area=%0d expected 0 0 0 0",
                     out_valid, out_index, out_sum, out_area);
        end

        // R8 R11: saturated row, restart carried on the first pixel
        tok_seen = 0; pushed = 0;
        drive_row(0, 0, COLS - 1, 1'b1, 0);
        idle(4);
        check_count("R8 saturated row");
        checks++;
        if (pushed != OUTS) begin
            errors++;
            $display("FAIL R8 tokens per row actual=%0d expected=%0d", pushed, OUTS);
        end

        // R1 R12: lone row_start pulse, quiet gap, then a ramp with irregular stalls
        tok_seen = 0; pushed = 0;
        @(negedge clk); row_start = 1'b1; pix_valid = 1'b0; model_clear();
        idle(3);
        drive_row(1, 0, COLS - 1, 1'b0, 5);
        idle(4);
        check_count("R12 stalled ramp");

        // R9: surplus pixels after the row end
        tok_seen = 0; pushed = 0;
        drive_row(2, 0, COLS - 1, 1'b1, 0);
        idle(2);
        check_count("R8 hashed row");
        tok_seen = 0;
        for (int k = 0; k < 20; k++) drive_pixel(k * 11, 1'b0);
        idle(3);
        checks++;
        if (tok_seen != 0) begin
            errors++;
            $display("FAIL R9 surplus pixel tokens actual=%0d expected=0", tok_seen);
        end

        // R10: partial row abandoned by a row_start that carries a pixel
        tok_seen = 0; pushed = 0;
        drive_row(3, 0, 99, 1'b1, 0);
        drive_row(2, 0, COLS - 1, 1'b1, 7);
        idle(4);
        check_count("R10 restart mid-row");

        idle(2);
        finish_run();
    end

endmodule